// File: doc/BRIEF.md
# Divider Setting Capture and Test-Output Select

This block holds the settings of a clock synthesizer's dividers: a feedback divider value (`cfg_m`, 9 bits by default), an output divider code (`cfg_n`, 3 bits) and a 2-bit test select (`cfg_t`). The settings arrive by one of two routes. In the first, the wide buses `par_m` and `par_n` are followed for as long as `par_hold` is low and are frozen when it rises. In the second, a 14-bit frame is shifted in over `ser_dat`/`ser_clk` and is moved into the settings under control of `ser_commit`. Either route can be transparent or latched, depending on the levels on the strobes. A serial transfer replaces whatever the parallel route last captured.

All strobes, the serial clock and the serial data pass through a synchronizer of `SYNC_STAGES` flops into `clk`. Their edges are detected in that clock domain. The serial clock must stay at or below a quarter of the `clk` rate. From a change on a pin to a change in the settings takes three rising edges of `clk`. The block also drives `test_out`, a single pin whose source is chosen by the test select. The master reset `mreset` only silences that pin. The system reset `rst_n` clears the synchronizers, the shift register and the test select.

Top module: `divcfg_iface`

## Requirements
- R1: After `rst_n` is released, `cfg_t` is 00, `cfg_m`/`cfg_n` follow `par_m`/`par_n`, and `test_out` is low.
- R2: While `par_hold` is low, `cfg_m` and `cfg_n` follow `par_m` and `par_n` within three `clk` edges.
- R3: On a rising `par_hold`, the values on `par_m`/`par_n` are captured. Later changes on those buses have no effect while `par_hold` stays high.
- R4: With `par_hold` high, each rising `ser_clk` shifts `ser_dat` into a 14-bit frame register. The first bit sent ends up as T1 (bit 13), then come T0, N2..N0, M8..M0. The frame layout is bits [13:12] = T, [11:9] = N, [8:0] = M.
- R5: A shifted frame leaves the settings unchanged until `ser_commit` rises. On that rise, all three fields are copied from the frame register.
- R6: After `ser_commit` falls, the settings hold, even while further frames are shifted in.
- R7: While both `ser_commit` and `par_hold` are high, every rising `ser_clk` copies the just-shifted frame register into the settings.
- R8: While `par_hold` is low, `ser_clk`, `ser_dat` and `ser_commit` change neither the frame register nor `cfg_t`.
- R9: With `par_hold` high and `mreset` low, `test_out` depends on `cfg_t`: 00 gives low, 01 gives the synchronized `ser_dat`, 10 gives `fb_tap`, and 11 gives `syn_tap`.
- R10: `test_out` is low whenever `par_hold` is low, whatever `cfg_t` holds.
- R11: `mreset` high forces `test_out` low and leaves `cfg_m`, `cfg_n` and `cfg_t` unchanged.
- R12: A serial commit after a parallel capture overrides the captured values with the frame register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is in this domain |
| rst_n | input | 1 | Active-low system reset |
| mreset | input | 1 | Master reset; silences the test pin only |
| par_hold | input | 1 | Low: follow parallel buses; rising: capture; high: serial mode |
| par_m | input | M_W | Parallel feedback divider value |
| par_n | input | N_W | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock (asynchronous, at most clk/4) |
| ser_dat | input | 1 | Serial frame data, first bit is T1 |
| ser_commit | input | 1 | Serial transfer strobe: rising copies, high is transparent |
| fb_tap | input | 1 | Feedback divider output, routed to the test pin for code 10 |
| syn_tap | input | 1 | Synthesizer output, routed to the test pin for code 11 |
| cfg_m | output | M_W | Active feedback divider value |
| cfg_n | output | N_W | Active output divider code |
| cfg_t | output | 2 | Active test select |
| test_out | output | 1 | Test pin |

## Verification
The bench goes after four kinds of mistake. The first is bit order: a frame shifted in with a reversed or misaligned field would put a wrong T or N into the settings once it is committed. The second is the border between the two routes. Serial activity while `par_hold` is low must not reach the frame register or `cfg_t`; a design that shifted anyway would commit a garbled frame when the later bare commit pulse copies the frame register. The third is serial transparency: a design without it would leave the settings stale while `ser_commit` is high, and a design that used the pre-shift frame would lag one bit behind. The fourth is `mreset`: a design that cleared the settings under it would lose the loaded M/N/T, and one that ignored it would keep driving the test pin.

// File: rtl/dcfg_pkg.sv
`timescale 1ns/1ps
package dcfg_pkg;
   localparam int TSEL_W = 2;

   typedef enum logic [TSEL_W-1:0] {
      TSEL_QUIET = 2'b00,
      TSEL_SDATA = 2'b01,
      TSEL_FBDIV = 2'b10,
      TSEL_SYNTH = 2'b11
   } tsel_e;

   // positions inside the synchronized control vector
   localparam int CTL_HOLD   = 0;
   localparam int CTL_SCLK   = 1;
   localparam int CTL_COMMIT = 2;
   localparam int CTL_DAT    = 3;
   localparam int CTL_W      = 4;
endpackage

// File: rtl/dcfg_sync.sv
`timescale 1ns/1ps
module dcfg_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dcfg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dcfg_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcfg_shift.sv
`timescale 1ns/1ps
module dcfg_shift #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               step,
   input  logic               din,
   output logic [FRAME_W-1:0] sr_nxt
);
   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("dcfg_shift: FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] sr_q;

   always_comb begin
      sr_nxt = sr_q;
      if (en && step) begin
         sr_nxt = {sr_q[FRAME_W-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else begin
         sr_q <= sr_nxt;
      end
   end

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step) |=> (sr_q[0] == $past(din))); // R4
   AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> $stable(sr_q)); // R8
endmodule

// File: rtl/dcfg_regs.sv
`timescale 1ns/1ps
module dcfg_regs #(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int T_W = 2,
   localparam int FRAME_W = M_W + N_W + T_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               par_lvl,
   input  logic               par_rise,
   input  logic               commit_lvl,
   input  logic               commit_rise,
   input  logic               sclk_rise,
   input  logic [M_W-1:0]     par_m,
   input  logic [N_W-1:0]     par_n,
   input  logic [FRAME_W-1:0] sr_nxt,
   output logic [M_W-1:0]     m_q,
   output logic [N_W-1:0]     n_q,
   output logic [T_W-1:0]     t_q
);
   localparam int N_LO = M_W;
   localparam int T_LO = M_W + N_W;

   logic load_par;
   logic xfer;

   // parallel route wins on the capture edge itself
   assign load_par = !par_lvl || par_rise;
   assign xfer     = par_lvl && !par_rise &&
                     (commit_rise || (commit_lvl && sclk_rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= '0;
         n_q <= '0;
         t_q <= '0;
      end else if (load_par) begin
         m_q <= par_m;
         n_q <= par_n;
      end else if (xfer) begin
         m_q <= sr_nxt[N_LO-1:0];
         n_q <= sr_nxt[T_LO-1:N_LO];
         t_q <= sr_nxt[FRAME_W-1:T_LO];
      end
   end

   AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_lvl) |=> ((m_q == $past(par_m)) && (n_q == $past(par_n)))); // R2
   AST_T_PAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_lvl) |=> $stable(t_q)); // R8
   AST_XFER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> ({t_q, n_q, m_q} == $past(sr_nxt))); // R5
endmodule

// File: rtl/dcfg_tmux.sv
`timescale 1ns/1ps
module dcfg_tmux
   import dcfg_pkg::*;
(
   input  logic              par_lvl,
   input  logic              mreset,
   input  logic [TSEL_W-1:0] tsel,
   input  logic              sdat,
   input  logic              fb_tap,
   input  logic              syn_tap,
   output logic              test_out
);
   tsel_e code;
   logic  picked;

   assign code = tsel_e'(tsel);

   always_comb begin
      unique case (code)
         TSEL_QUIET: picked = 1'b0;
         TSEL_SDATA: picked = sdat;
         TSEL_FBDIV: picked = fb_tap;
         TSEL_SYNTH: picked = syn_tap;
         default:    picked = 1'b0;
      endcase
   end

   assign test_out = par_lvl && !mreset && picked;
endmodule

// File: rtl/divcfg_iface.sv
`timescale 1ns/1ps
module divcfg_iface
   import dcfg_pkg::*;
#(
   parameter int M_W         = 9,
   parameter int N_W         = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mreset,
   input  logic              par_hold,
   input  logic [M_W-1:0]    par_m,
   input  logic [N_W-1:0]    par_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_commit,
   input  logic              fb_tap,
   input  logic              syn_tap,
   output logic [M_W-1:0]    cfg_m,
   output logic [N_W-1:0]    cfg_n,
   output logic [TSEL_W-1:0] cfg_t,
   output logic              test_out
);
   localparam int FRAME_W = M_W + N_W + TSEL_W;
   localparam int EDGE_W  = CTL_DAT;

   logic [CTL_W-1:0]  ctl_raw;
   logic [CTL_W-1:0]  ctl_lvl;
   logic [EDGE_W-1:0] ctl_prev;
   logic [EDGE_W-1:0] ctl_rise;
   logic [FRAME_W-1:0] sr_nxt;

   assign ctl_raw[CTL_HOLD]   = par_hold;
   assign ctl_raw[CTL_SCLK]   = ser_clk;
   assign ctl_raw[CTL_COMMIT] = ser_commit;
   assign ctl_raw[CTL_DAT]    = ser_dat;

   dcfg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_prev <= '0;
      end else begin
         ctl_prev <= ctl_lvl[EDGE_W-1:0];
      end
   end

   assign ctl_rise = ctl_lvl[EDGE_W-1:0] & ~ctl_prev;

   dcfg_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctl_lvl[CTL_HOLD]),
      .step   (ctl_rise[CTL_SCLK]),
      .din    (ctl_lvl[CTL_DAT]),
      .sr_nxt (sr_nxt)
   );

   dcfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(TSEL_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .par_lvl     (ctl_lvl[CTL_HOLD]),
      .par_rise    (ctl_rise[CTL_HOLD]),
      .commit_lvl  (ctl_lvl[CTL_COMMIT]),
      .commit_rise (ctl_rise[CTL_COMMIT]),
      .sclk_rise   (ctl_rise[CTL_SCLK]),
      .par_m       (par_m),
      .par_n       (par_n),
      .sr_nxt      (sr_nxt),
      .m_q         (cfg_m),
      .n_q         (cfg_n),
      .t_q         (cfg_t)
   );

   dcfg_tmux u_tmux (
      .par_lvl  (ctl_lvl[CTL_HOLD]),
      .mreset   (mreset),
      .tsel     (cfg_t),
      .sdat     (ctl_lvl[CTL_DAT]),
      .fb_tap   (fb_tap),
      .syn_tap  (syn_tap),
      .test_out (test_out)
   );

   AST_QUIET_PAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_lvl[CTL_HOLD]) |-> (!test_out)); // R10
endmodule

// File: tb/divcfg_iface_bench.sv
`timescale 1ns/1ps
module divcfg_iface_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mreset = 1'b0;
   logic       par_hold = 1'b0;
   logic [8:0] par_m = '0;
   logic [2:0] par_n = '0;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       ser_commit = 1'b0;
   logic       fb_tap = 1'b0;
   logic       syn_tap = 1'b0;
   logic [8:0] cfg_m;
   logic [2:0] cfg_n;
   logic [1:0] cfg_t;
   logic       test_out;

   int checks = 0;
   int failures = 0;
   logic [13:0] sr_model = '0;

   always #2.5 clk = ~clk;

   divcfg_iface u_divcfg_iface (
      .clk(clk), .rst_n(rst_n), .mreset(mreset), .par_hold(par_hold),
      .par_m(par_m), .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_commit(ser_commit), .fb_tap(fb_tap), .syn_tap(syn_tap),
      .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .test_out(test_out)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_cfg(input string req, input logic [8:0] m,
                            input logic [2:0] n, input logic [1:0] t);
      check(req, "cfg_m", 32'(cfg_m), 32'(m));
      check(req, "cfg_n", 32'(cfg_n), 32'(n));
      check(req, "cfg_t", 32'(cfg_t), 32'(t));
   endtask

   task automatic raw_bit(input logic b);
      ser_dat = b;
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
      wait_n(4);
   endtask

   task automatic send_bit(input logic b);
      raw_bit(b);
      sr_model = {sr_model[12:0], b};
   endtask

   task automatic send_frame(input logic [1:0] t, input logic [2:0] n, input logic [8:0] m);
      logic [13:0] f;
      f = {t, n, m};
      for (int i = 13; i >= 0; i--) send_bit(f[i]);
   endtask

   task automatic pulse_commit();
      ser_commit = 1'b1;
      wait_n(4);
      ser_commit = 1'b0;
      wait_n(4);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      par_m = 9'h0A5;
      par_n = 3'd3;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(4);
      check_cfg("R1", 9'h0A5, 3'd3, 2'b00);
      check("R1", "test_out", 32'(test_out), 32'h0);
   endtask

   task automatic t_par_track();
      par_m = 9'h100; par_n = 3'd0;
      wait_n(4);
      check_cfg("R2", 9'h100, 3'd0, 2'b00);
      par_m = 9'h1F3; par_n = 3'd5;
      wait_n(4);
      check_cfg("R2", 9'h1F3, 3'd5, 2'b00);
   endtask

   task automatic t_par_capture();
      par_hold = 1'b1;
      wait_n(4);
      par_m = 9'h011; par_n = 3'd2;
      wait_n(4);
      check_cfg("R3", 9'h1F3, 3'd5, 2'b00);
      check("R9", "test_out code00", 32'(test_out), 32'h0);
   endtask

   task automatic t_serial_commit();
      send_frame(2'b01, 3'd6, 9'h15A);
      check_cfg("R5", 9'h1F3, 3'd5, 2'b00);
      pulse_commit();
      check_cfg("R4", 9'h15A, 3'd6, 2'b01);
      send_frame(2'b10, 3'd1, 9'h0C3);
      check_cfg("R6", 9'h15A, 3'd6, 2'b01);
   endtask

   task automatic t_serial_transparent();
      ser_commit = 1'b1;
      wait_n(4);
      check_cfg("R5", 9'h0C3, 3'd1, 2'b10);
      send_bit(1'b1);
      check_cfg("R7", sr_model[8:0], sr_model[11:9], sr_model[13:12]);
      send_bit(1'b0);
      check_cfg("R7", sr_model[8:0], sr_model[11:9], sr_model[13:12]);
      send_bit(1'b1);
      check_cfg("R7", sr_model[8:0], sr_model[11:9], sr_model[13:12]);
      ser_commit = 1'b0;
      wait_n(4);
   endtask

   task automatic t_test_mux();
      send_frame(2'b01, 3'd4, 9'h0AA);
      pulse_commit();
      check_cfg("R4", 9'h0AA, 3'd4, 2'b01);
      ser_dat = 1'b1; wait_n(4);
      check("R9", "test_out code01 hi", 32'(test_out), 32'h1);
      ser_dat = 1'b0; wait_n(4);
      check("R9", "test_out code01 lo", 32'(test_out), 32'h0);
      send_frame(2'b10, 3'd7, 9'h155);
      pulse_commit();
      fb_tap = 1'b1; wait_n(1);
      check("R9", "test_out code10 hi", 32'(test_out), 32'h1);
      fb_tap = 1'b0; wait_n(1);
      check("R9", "test_out code10 lo", 32'(test_out), 32'h0);
      send_frame(2'b11, 3'd2, 9'h07E);
      pulse_commit();
      syn_tap = 1'b1; wait_n(1);
      check("R9", "test_out code11 hi", 32'(test_out), 32'h1);
      mreset = 1'b1; wait_n(4);
      check("R11", "test_out under mreset", 32'(test_out), 32'h0);
      check_cfg("R11", 9'h07E, 3'd2, 2'b11);
      mreset = 1'b0; wait_n(1);
      check("R11", "test_out after mreset", 32'(test_out), 32'h1);
   endtask

   task automatic t_par_mode();
      par_m = 9'h0F0; par_n = 3'd4;
      par_hold = 1'b0;
      wait_n(4);
      check("R10", "test_out parallel", 32'(test_out), 32'h0);
      check_cfg("R2", 9'h0F0, 3'd4, 2'b11);
      raw_bit(1'b1);
      raw_bit(1'b0);
      ser_commit = 1'b1;
      raw_bit(1'b1);
      ser_commit = 1'b0;
      wait_n(4);
      check_cfg("R8", 9'h0F0, 3'd4, 2'b11);
      par_m = 9'h033; par_n = 3'd6;
      wait_n(4);
      check_cfg("R2", 9'h033, 3'd6, 2'b11);
      par_hold = 1'b1;
      wait_n(4);
      check_cfg("R3", 9'h033, 3'd6, 2'b11);
      pulse_commit();
      check_cfg("R12", sr_model[8:0], sr_model[11:9], sr_model[13:12]);
      check_cfg("R8", 9'h07E, 3'd2, 2'b11);
   endtask

   initial begin
      t_reset();
      t_par_track();
      t_par_capture();
      t_serial_commit();
      t_serial_transparent();
      t_test_mux();
      t_par_mode();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule